// File: doc/BRIEF.md
# Graphics Layer Memory Paging Controller

This block is a byte-wide I/O register at port address 0x123B. It lets the CPU see the frame buffer of a graphics layer in the lowest part of its 64 KiB address space. A byte written to the port has two meanings, selected by its bit 4:

- With bit 4 clear, the byte sets the control fields: the window mode, the page source, the two direction enables and the visible flag.
- With bit 4 set, the byte sets only a relative bank offset. This lets a 16 KiB window step past the first three banks of the buffer.

For every CPU memory access the block decides, without a clock, whether the access goes to frame-buffer RAM. When it does, the block forms the physical 16 KiB bank and the byte offset inside that bank. The base bank comes from one of two page registers kept outside this block: the main page or the shadow page. The displayed buffer always follows the main page. The shadow page therefore lets software draw into one buffer while another buffer is on screen. The block also drives the layer-visible flag to the display side.

Top module: `fb_page_ctrl`

## Requirements
- R1: A port write (`io_wr` high, `io_addr` = 0x123B) whose data has bit 4 = 0 stores its fields on the next rising clock edge:
  - bits 7-6: window mode (0, 1, 2 = 16 KiB window showing segment 0, 1 or 2; 3 = 48 KiB window)
  - bit 3: page source
  - bit 2: read enable
  - bit 1: visible
  - bit 0: write enable
  
  Writes to any other I/O address change nothing.
- R2: A port write whose data has bit 4 = 1 stores data bits 2-0 as the relative bank offset (0..7). All control fields keep their values.
- R3: When `io_addr` = 0x123B, `io_rdata` returns the stored window mode in bits 7-6 and bits 3-0 as stored, with bits 5 and 4 reading 0. At any other address `io_rdata` is 0.
- R4: Synchronous active-high `rst` clears all control fields and the offset to 0. After reset no access is redirected and the layer is not visible.
- R5: In the 16 KiB modes, an enabled access hits only when CPU address bits 15-14 are 0. The mapped bank is base + offset + mode (0..2).
- R6: In the 48 KiB mode, an enabled access hits when CPU address bits 15-14 are 0, 1 or 2. The mapped bank is base + offset + address bits 15-14. Addresses from 0xC000 up never hit.
- R7: The base bank is `main_page` when the page source bit is 0 and `shadow_page` when it is 1.
- R8: A read (`cpu_rd`) is redirected only when the read enable is set, and a write (`cpu_wr`) only when the write enable is set. Each direction is gated on its own, and there is no hit without a strobe.
- R9: `layer_visible` equals the stored visible bit whatever the page source.
- R10: `map_paddr` is the mapped bank followed by CPU address bits 13-0. The bank sum wraps modulo 2^BANK_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high soft reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (0 when the port is not addressed) |
| main_page | input | BANK_W | Main page register: first bank of the displayed buffer |
| shadow_page | input | BANK_W | Shadow page register: alternative base bank for CPU mapping |
| cpu_addr | input | 16 | CPU memory address |
| cpu_rd | input | 1 | CPU memory read strobe |
| cpu_wr | input | 1 | CPU memory write strobe |
| map_hit | output | 1 | Access is redirected to frame-buffer RAM |
| map_bank | output | BANK_W | Mapped 16 KiB bank |
| map_paddr | output | BANK_W+14 | Physical frame-buffer byte address |
| layer_visible | output | 1 | Layer visible flag to the display |

## Verification
The mapping path has no registers, so a corrupt control field or offset shows up at the ports in the first cycle after the port write that set it:
- `map_bank` moves by the wrong step, or
- `map_hit` appears or disappears at a window edge or for one strobe direction.

A control field overwritten by an offset write, or the reverse, shows on `io_rdata` right away and in the very next mapped access. The bench therefore applies every write, then reads the port back and probes the window edges in the same cycle.

// File: rtl/fb_page_pkg.sv
package fb_page_pkg;

    localparam logic [15:0] PORT_ADDR = 16'h123B;
    localparam int          OFS_W     = 3;
    localparam int          WIN_LSB   = 14;   // 16 KiB windows
    localparam int          SEG_W     = 16 - WIN_LSB;

    typedef enum logic [1:0] {
        WIN_SEG0  = 2'd0,
        WIN_SEG1  = 2'd1,
        WIN_SEG2  = 2'd2,
        WIN_ALL48 = 2'd3
    } win_mode_e;

    typedef struct packed {
        win_mode_e mode;
        logic      use_shadow;
        logic      rd_en;
        logic      visible;
        logic      wr_en;
    } page_ctrl_t;

    function automatic page_ctrl_t decode_ctrl(input logic [7:0] b);
        page_ctrl_t c;
        c.mode       = win_mode_e'(b[7:6]);
        c.use_shadow = b[3];
        c.rd_en      = b[2];
        c.visible    = b[1];
        c.wr_en      = b[0];
        return c;
    endfunction

    function automatic logic [7:0] encode_ctrl(input page_ctrl_t c);
        return {c.mode, 2'b00, c.use_shadow, c.rd_en, c.visible, c.wr_en};
    endfunction

endpackage

// File: rtl/fb_port_regs.sv
module fb_port_regs
    import fb_page_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      io_addr,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    output logic             port_sel,
    output page_ctrl_t       ctrl_q,
    output logic [OFS_W-1:0] ofs_q
);

    logic port_wr;
    logic ofs_form;

    assign port_sel = (io_addr == PORT_ADDR);
    assign port_wr  = port_sel && io_wr;
    assign ofs_form = io_wdata[4];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (port_wr && !ofs_form) begin
            ctrl_q <= decode_ctrl(io_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q <= '0;
        end else if (port_wr && ofs_form) begin
            ofs_q <= io_wdata[OFS_W-1:0];
        end
    end

endmodule

// File: rtl/fb_window_map.sv
module fb_window_map
    import fb_page_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  page_ctrl_t             ctrl,
    input  logic [OFS_W-1:0]       ofs,
    input  logic [BANK_W-1:0]      main_page,
    input  logic [BANK_W-1:0]      shadow_page,
    input  logic [15:0]            cpu_addr,
    input  logic                   cpu_rd,
    input  logic                   cpu_wr,
    output logic                   hit,
    output logic [BANK_W-1:0]      bank,
    output logic [BANK_W+WIN_LSB-1:0] paddr
);

    logic [BANK_W-1:0] base;
    logic [SEG_W-1:0]  blk;
    logic [SEG_W-1:0]  seg_idx;
    logic              wide;
    logic              in_win;
    logic              enabled;

    assign blk  = cpu_addr[15:WIN_LSB];
    assign wide = (ctrl.mode == WIN_ALL48);

    always_comb begin
        base    = ctrl.use_shadow ? shadow_page : main_page;
        seg_idx = wide ? blk : SEG_W'(ctrl.mode);
        in_win  = wide ? (blk != 2'd3) : (blk == 2'd0);
        enabled = (cpu_rd && ctrl.rd_en) || (cpu_wr && ctrl.wr_en);
        bank    = base + BANK_W'(ofs) + BANK_W'(seg_idx);
    end

    assign hit   = enabled && in_win;
    assign paddr = {bank, cpu_addr[WIN_LSB-1:0]};

endmodule

// File: rtl/fb_page_ctrl.sv
module fb_page_ctrl
    import fb_page_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [15:0]               io_addr,
    input  logic                      io_wr,
    input  logic [7:0]                io_wdata,
    output logic [7:0]                io_rdata,
    input  logic [BANK_W-1:0]         main_page,
    input  logic [BANK_W-1:0]         shadow_page,
    input  logic [15:0]               cpu_addr,
    input  logic                      cpu_rd,
    input  logic                      cpu_wr,
    output logic                      map_hit,
    output logic [BANK_W-1:0]         map_bank,
    output logic [BANK_W+WIN_LSB-1:0] map_paddr,
    output logic                      layer_visible
);

    logic             port_sel;
    page_ctrl_t       ctrl_q;
    logic [OFS_W-1:0] ofs_q;

    fb_port_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .port_sel (port_sel),
        .ctrl_q   (ctrl_q),
        .ofs_q    (ofs_q)
    );

    fb_window_map #(.BANK_W(BANK_W)) u_map (
        .ctrl        (ctrl_q),
        .ofs         (ofs_q),
        .main_page   (main_page),
        .shadow_page (shadow_page),
        .cpu_addr    (cpu_addr),
        .cpu_rd      (cpu_rd),
        .cpu_wr      (cpu_wr),
        .hit         (map_hit),
        .bank        (map_bank),
        .paddr       (map_paddr)
    );

    assign io_rdata      = port_sel ? encode_ctrl(ctrl_q) : 8'h00;
    assign layer_visible = ctrl_q.visible;

endmodule

// File: rtl/fb_page_ctrl_chk.sv
module fb_page_ctrl_chk
    import fb_page_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic [15:0]               io_addr,
    input logic                      io_wr,
    input logic [7:0]                io_wdata,
    input logic [15:0]               cpu_addr,
    input logic                      cpu_rd,
    input logic                      cpu_wr,
    input logic                      map_hit,
    input logic [BANK_W+WIN_LSB-1:0] map_paddr,
    input page_ctrl_t                ctrl_q,
    input logic [OFS_W-1:0]          ofs_q
);

    logic pwr;
    logic seen_clk;
    assign pwr = io_wr && (io_addr == PORT_ADDR);

    always_ff @(posedge clk) seen_clk <= 1'b1;

    // R1: without a port write the control fields hold
    p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !pwr |=> $stable(ctrl_q));

    // R2: an offset-form write leaves the control fields alone
    p_ofs_form_keeps_ctrl_r2: assert property (@(posedge clk) disable iff (rst)
        (pwr && io_wdata[4]) |=> $stable(ctrl_q));

    // R2: a control-form write leaves the offset alone
    p_ctrl_form_keeps_ofs_r2: assert property (@(posedge clk) disable iff (rst)
        (pwr && !io_wdata[4]) |=> $stable(ofs_q));

    // R4: reset clears all stored state
    p_reset_clear_r4: assert property (@(posedge clk)
        (seen_clk && $past(rst)) |-> (ctrl_q == '0 && ofs_q == '0));

    // R6: the top quarter of the address space never hits
    p_no_top_hit_r6: assert property (@(posedge clk) disable iff (rst)
        map_hit |-> (cpu_addr[15:14] != 2'd3));

    // R8: no hit without a strobe
    p_hit_needs_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        map_hit |-> (cpu_rd || cpu_wr));

    // R10: the byte offset passes through unchanged
    p_offset_pass_r10: assert property (@(posedge clk) disable iff (rst)
        map_hit |-> (map_paddr[WIN_LSB-1:0] == cpu_addr[WIN_LSB-1:0]));

endmodule

bind fb_page_ctrl fb_page_ctrl_chk #(.BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .map_hit   (map_hit),
    .map_paddr (map_paddr),
    .ctrl_q    (ctrl_q),
    .ofs_q     (ofs_q)
);

// File: tb/fb_page_ctrl_bench.sv
module fb_page_ctrl_bench;

    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   io_addr = '0;
    logic          io_wr = 1'b0;
    logic [7:0]    io_wdata = '0;
    logic [7:0]    io_rdata;
    logic [BW-1:0] main_page = '0;
    logic [BW-1:0] shadow_page = '0;
    logic [15:0]   cpu_addr = '0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic          map_hit;
    logic [BW-1:0] map_bank;
    logic [BW+13:0] map_paddr;
    logic          layer_visible;

    int n_chk = 0;
    int n_bad = 0;

    // bench view of what was written
    logic [7:0] m_ctl = 8'h00;
    logic [2:0] m_ofs = 3'd0;

    always #10 clk = ~clk;   // 50 MHz

    fb_page_ctrl #(.BANK_W(BW)) u_fb_page_ctrl (
        .clk(clk), .rst(rst),
        .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .main_page(main_page), .shadow_page(shadow_page),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .map_hit(map_hit), .map_bank(map_bank), .map_paddr(map_paddr),
        .layer_visible(layer_visible)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic port_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == 16'h123B) begin
            if (d[4]) m_ofs = d[2:0];
            else      m_ctl = {d[7:6], 2'b00, d[3:0]};
        end
    endtask

    task automatic check_readback(input string req);
        io_addr = 16'h123B;
        #1;
        check(req, io_rdata, m_ctl);
    endtask

    // expected mapping, computed from the requirement text
    task automatic probe(input string req, input logic [15:0] a, input logic rd, input logic wr);
        logic [1:0]    mode;
        logic [1:0]    blk;
        logic [1:0]    seg;
        logic          win;
        logic          en;
        logic [BW-1:0] base;
        logic [BW-1:0] ebank;
        mode = m_ctl[7:6];
        blk  = a[15:14];
        seg  = (mode == 2'd3) ? blk : mode;
        win  = (mode == 2'd3) ? (blk != 2'd3) : (blk == 2'd0);
        en   = (rd && m_ctl[2]) || (wr && m_ctl[0]);
        base = m_ctl[3] ? shadow_page : main_page;
        ebank = base + BW'(m_ofs) + BW'(seg);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
        #1;
        check(req, map_hit, en && win);
        if (en && win) begin
            check(req, map_bank, ebank);
            check(req, map_paddr, {ebank, a[13:0]});
        end
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic t_reset;
        check_readback("R4 readback after reset");
        check("R4 visible", layer_visible, 1'b0);
        main_page = 8'h10;
        probe("R4 no hit", 16'h0123, 1'b1, 1'b1);
    endtask

    task automatic t_ctrl_write;
        port_write(16'h123B, 8'hEF);      // all fields set, bit 4 clear
        check_readback("R1 stored fields / R3 bits 5,4 read 0");
        check("R3 value", io_rdata, 8'hCF);
        io_addr = 16'h123A; #1;
        check("R3 other address reads 0", io_rdata, 8'h00);
        port_write(16'h123C, 8'h00);      // wrong address, ignored
        check_readback("R1 other address ignored");
        check("R1 visible kept", layer_visible, 1'b1);
    endtask

    task automatic t_offset_write;
        port_write(16'h123B, 8'h01);      // seg0, write enable only
        port_write(16'h123B, 8'hF3);      // offset form, offset 3
        check_readback("R2 control fields kept");
        check("R2 value", io_rdata, 8'h01);
        main_page = 8'h08;
        probe("R2 offset applied", 16'h1234, 1'b0, 1'b1);
        check("R2 bank", map_bank, 8'h0B);
    endtask

    task automatic t_win16;
        port_write(16'h123B, 8'h85);      // seg2, rd+wr enable
        port_write(16'h123B, 8'h10);      // offset 0
        main_page = 8'h20;
        probe("R5 seg2 low window", 16'h3FFF, 1'b1, 1'b0);
        probe("R5 above window", 16'h4000, 1'b1, 1'b0);
        port_write(16'h123B, 8'h45);      // seg1
        probe("R5 seg1", 16'h0000, 1'b0, 1'b1);
        check("R5 bank seg1", map_bank, 8'h21);
    endtask

    task automatic t_win48;
        port_write(16'h123B, 8'hC5);      // 48K mode
        port_write(16'h123B, 8'h12);      // offset 2
        main_page = 8'h30;
        probe("R6 block0", 16'h0010, 1'b1, 1'b0);
        probe("R6 block1", 16'h7FFF, 1'b1, 1'b0);
        probe("R6 block2", 16'hBFFF, 1'b0, 1'b1);
        check("R6 bank block2", map_bank, 8'h34);
        probe("R6 top no hit", 16'hC000, 1'b1, 1'b1);
        check("R6 top hit", map_hit, 1'b0);
    endtask

    task automatic t_shadow;
        port_write(16'h123B, 8'h0F);      // shadow, rd/wr enable, visible
        port_write(16'h123B, 8'h10);
        main_page = 8'h40; shadow_page = 8'h50;
        probe("R7 shadow base", 16'h0100, 1'b1, 1'b0);
        check("R7 shadow bank", map_bank, 8'h50);
        check("R9 visible with shadow", layer_visible, 1'b1);
        port_write(16'h123B, 8'h05);      // main, not visible
        probe("R7 main base", 16'h0100, 1'b1, 1'b0);
        check("R9 not visible", layer_visible, 1'b0);
    endtask

    task automatic t_gating;
        port_write(16'h123B, 8'h04);      // read enable only
        probe("R8 read enabled", 16'h0200, 1'b1, 1'b0);
        probe("R8 write blocked", 16'h0200, 1'b0, 1'b1);
        check("R8 write blocked hit", map_hit, 1'b0);
        port_write(16'h123B, 8'h01);      // write enable only
        probe("R8 read blocked", 16'h0200, 1'b1, 1'b0);
        probe("R8 write enabled", 16'h0200, 1'b0, 1'b1);
        check("R8 write enabled hit", map_hit, 1'b1);
        probe("R8 no strobe", 16'h0200, 1'b0, 1'b0);
    endtask

    task automatic t_wrap;
        port_write(16'h123B, 8'h85);      // seg2
        port_write(16'h123B, 8'h17);      // offset 7
        main_page = 8'hFE;
        probe("R10 wrap", 16'h2ABC, 1'b1, 1'b0);
        check("R10 wrapped bank", map_bank, 8'h07);
        check("R10 paddr", map_paddr, {8'h07, 14'h2ABC});
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_ctl = 8'h00; m_ofs = 3'd0;
        check_readback("R4 second reset ctrl");
        port_write(16'h123B, 8'h05);
        main_page = 8'h60;
        probe("R4 offset cleared", 16'h0000, 1'b1, 1'b0);
        check("R4 offset bank", map_bank, 8'h60);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_write();
        t_offset_write();
        t_win16();
        t_win48();
        t_shadow();
        t_gating();
        t_wrap();
        t_reset_again();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule